// File: doc/BRIEF.md
# Dual Configuration Register Serial Target

This block is a two-wire serial bus target (I2C-style, 7-bit addressing) that gives an external bus controller access to two 8-bit configuration registers. The bus lines arrive as raw levels. Each line passes through a two-flop synchronizer and a run-length glitch filter. The block pulls SDA low through an open-drain enable and never stretches SCL. Both registers appear as parallel outputs. The low six bits of register 0 are also brought out as a margin code, an unsigned count in steps of 12.5 mV.

A controller writes a pointer byte after the address. Any data bytes that follow are stored starting at the register the pointer selects. The pointer is kept after STOP. A later read transaction therefore returns the register chosen by an earlier pointer-only write. Bursts that start at register 0 move on to register 1 and then stay there. A dedicated clear input zeroes both registers at once, asynchronously, and leaves the pointer and any transaction in progress untouched. The main reset clears everything.

Top module: `dual_cfg_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal the TGT_ADDR parameter. On any other address it leaves SDA released until the next START.
- R2: A write transaction (address with bit 0 = 0, pointer byte, data byte) acknowledges every byte and stores the data byte in the register selected by the pointer: 0x00 selects register 0 and 0x01 selects register 1.
- R3: In a write burst with pointer 0x00, the first data byte goes to register 0 and the second to register 1. Any further byte overwrites register 1.
- R4: A pointer value above 0x01 is acknowledged. Data bytes written to it are acknowledged and change no register, and a read from it returns 0x00.
- R5: The pointer survives a STOP. A read transaction (address with bit 0 = 1) that follows a pointer-only write returns the selected register, MSB first.
- R6: During a read, a controller ACK after a byte makes the target send the next register. After a controller NACK the target releases SDA until STOP or START.
- R7: The pointer advances by one after each byte written or read while it equals 0x00. It never advances beyond 0x01.
- R8: An active-low reset clears both registers and the pointer and returns the bus logic to idle.
- R9: Driving regClrN low clears both registers immediately without a clock edge. It does not affect the pointer or a transaction in progress.
- R10: marginCode always equals bits 5:0 of register 0.
- R11: The SDA drive enable changes only while SCL is low.
- R12: A repeated START in any state returns the target to address reception, and a STOP in any state returns it to idle. A partially received byte is then discarded.
- R13: An SCL pulse shorter than FILT_CYC clock cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset of the whole block |
| regClrN | input | 1 | Active-low asynchronous clear of the two registers only |
| sclIn | input | 1 | Raw SCL level from the bus |
| sdaIn | input | 1 | Raw SDA level from the bus |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| cfgReg0 | output | 8 | Contents of register 0 |
| cfgReg1 | output | 8 | Contents of register 1 |
| marginCode | output | 6 | Offset code field of register 0 |

## Verification
Single-byte writes to each pointer, and a pointer-only write followed by a read, show whether the pointer is decoded and whether it is kept across STOP. Two- and three-byte write bursts and a two-byte read with ACK, followed by a further single read, separate a correct auto-increment from wrap-around or from no increment. A pointer of 0x05, a wrong address, and aborts by repeated START and by STOP in the middle of a byte expose writes that should not happen. A register clear in the middle of a transaction, a full reset, and a short SCL glitch inside a data byte check that clearing and filtering have no side effects on the rest of the logic.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 2;
  localparam int MARGIN_W = 6;
  localparam int BIT_CW   = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tgtState_t;

  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic shiftOut;  // move to the next transmit bit
    logic loadTx;    // load the selected register for transmit
    logic loadPtr;   // take the received byte as pointer
    logic wrReg;     // store the received byte, then advance the pointer
    logic incPtr;    // advance the pointer after a byte has been sent
  } dpStrobe_t;
endpackage

// File: rtl/i2cLineFilt.sv
module i2cLineFilt #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] runCnt;
  logic             cleanQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      runCnt <= '0;
      cleanQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanQ) begin
        runCnt <= '0;
      end else if (runCnt == CNT_W'(FILT_CYC - 1)) begin
        cleanQ <= syncQ[1];
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign cleanOut = cleanQ;

  // R13: the filtered level flips only after a full run of differing samples
  p_filter_run_r13: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cleanQ) |-> ($past(syncQ[1]) == cleanQ) && ($past(runCnt) == CNT_W'(FILT_CYC - 1)));
endmodule

// File: rtl/i2cTgtData.sv
module i2cTgtData
  import i2cRegPkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                regClrN,
  input  dpStrobe_t                           stb,
  input  logic                                sdaBit,
  output logic [BYTE_W-1:0]                   rxByte,
  output logic                                txBit,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]     regOut
);
  logic [BYTE_W-1:0]               shiftReg;
  logic [BYTE_W-1:0]               ptr;
  logic [BYTE_W-1:0]               txSel;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regQ;
  logic                            regRstN;
  logic                            ptrCanStep;

  assign regRstN    = rstN & regClrN;
  assign ptrCanStep = ptr < BYTE_W'(NUM_REGS - 1);

  always_comb begin
    txSel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr == BYTE_W'(i)) txSel = regQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.loadTx) begin
      shiftReg <= txSel;
    end else if (stb.shiftIn) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
    end else if (stb.shiftOut) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.loadPtr) begin
      ptr <= shiftReg;
    end else if ((stb.wrReg || stb.incPtr) && ptrCanStep) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge regRstN) begin
      if (!regRstN) begin
        regQ[g] <= '0;
      end else if (stb.wrReg && (ptr == BYTE_W'(g))) begin
        regQ[g] <= shiftReg;
      end
    end
  end

  assign rxByte = shiftReg;
  assign txBit  = shiftReg[BYTE_W-1];
  assign regOut = regQ;

  // R4: a store through an unmapped pointer leaves every register unchanged
  p_wild_ptr_ignored_r4: assert property (@(posedge clk) disable iff (!regRstN)
    stb.wrReg && (ptr >= BYTE_W'(NUM_REGS)) |=> $stable(regQ));

  // R7: the pointer never moves past the last register
  p_ptr_saturate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrReg || stb.incPtr) && (ptr == BYTE_W'(NUM_REGS - 1)) |=> ptr == BYTE_W'(NUM_REGS - 1));

  // R9: while the clear is held, both registers read zero
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !regClrN |-> (regQ == '0));

  // R9: the clear does not touch the pointer
  p_clear_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rstN)
    !regClrN && !stb.loadPtr && !stb.wrReg && !stb.incPtr |=> $stable(ptr));
endmodule

// File: rtl/i2cTgtCtrl.sv
module i2cTgtCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h4C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  output dpStrobe_t         stb,
  output logic              sdaOe
);
  localparam logic [BIT_CW-1:0] FULL_CNT = BIT_CW'(BYTE_W);

  tgtState_t         state, stNext;
  logic [BIT_CW-1:0] bitCnt, cntNext;
  logic              sclQ, sdaQ;
  logic              rwBit, rwNext;
  logic              sdaOeR, oeNext;
  logic              mAck, ackNext;
  logic              sclRise, sclFall, startDet, stopDet;

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;

  always_comb begin
    stNext  = state;
    cntNext = bitCnt;
    rwNext  = rwBit;
    oeNext  = sdaOeR;
    ackNext = mAck;
    stb     = '0;
    if (startDet) begin
      stNext  = ST_ADDR;
      cntNext = '0;
      oeNext  = 1'b0;
    end else if (stopDet) begin
      stNext = ST_IDLE;
      oeNext = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise && (bitCnt < FULL_CNT)) begin
            stb.shiftIn = 1'b1;
            cntNext     = bitCnt + 1'b1;
          end else if (sclFall && (bitCnt == FULL_CNT)) begin
            cntNext = '0;
            if (state == ST_ADDR) begin
              if (rxByte[BYTE_W-1:1] == TGT_ADDR) begin
                oeNext = 1'b1;
                rwNext = rxByte[0];
                stNext = ST_ADDR_ACK;
              end else begin
                stNext = ST_IGNORE;
              end
            end else if (state == ST_PTR) begin
              stb.loadPtr = 1'b1;
              oeNext      = 1'b1;
              stNext      = ST_PTR_ACK;
            end else begin
              stb.wrReg = 1'b1;
              oeNext    = 1'b1;
              stNext    = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            cntNext = '0;
            if (rwBit) begin
              stb.loadTx = 1'b1;
              stNext     = ST_RDATA;
            end else begin
              oeNext = 1'b0;
              stNext = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            oeNext  = 1'b0;
            cntNext = '0;
            stNext  = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            cntNext = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == FULL_CNT) begin
              oeNext     = 1'b0;
              stb.incPtr = 1'b1;
              stNext     = ST_RACK;
            end else begin
              stb.shiftOut = 1'b1;
            end
          end else if (!sclF && (bitCnt != FULL_CNT)) begin
            oeNext = ~txBit;
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            ackNext = ~sdaF;
          end else if (sclFall) begin
            cntNext = '0;
            if (mAck) begin
              stb.loadTx = 1'b1;
              stNext     = ST_RDATA;
            end else begin
              stNext = ST_IGNORE;
            end
          end
        end
        ST_IDLE, ST_IGNORE: ;
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sclQ   <= 1'b1;
      sdaQ   <= 1'b1;
      rwBit  <= 1'b0;
      sdaOeR <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      state  <= stNext;
      bitCnt <= cntNext;
      sclQ   <= sclF;
      sdaQ   <= sdaF;
      rwBit  <= rwNext;
      sdaOeR <= oeNext;
      mAck   <= ackNext;
    end
  end

  assign sdaOe = sdaOeR;

  // R11: the drive enable moves only while the filtered clock is low
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOeR) |-> !sclF);

  // R12: a STOP always lands in idle
  p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> state == ST_IDLE);

  // R12: a START always restarts address reception
  p_start_addr_r12: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR) && (bitCnt == '0));

  // R1: a target that is not addressed keeps the line released
  p_ignore_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IGNORE |-> !sdaOeR);

  // R6: the acknowledge slot of a read belongs to the controller
  p_rack_released_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RACK |-> !sdaOeR);
endmodule

// File: rtl/dual_cfg_i2c_target.sv
module dual_cfg_i2c_target
  import i2cRegPkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h4C,
  parameter int         FILT_CYC = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regClrN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaOe,
  output logic [BYTE_W-1:0]   cfgReg0,
  output logic [BYTE_W-1:0]   cfgReg1,
  output logic [MARGIN_W-1:0] marginCode
);
  logic [1:0]                      lineRaw, lineClean;
  dpStrobe_t                       stb;
  logic [BYTE_W-1:0]               rxByte;
  logic                            txBit;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regOut;

  assign lineRaw = {sdaIn, sclIn};

  for (genvar li = 0; li < 2; li++) begin : g_line
    i2cLineFilt #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (lineRaw[li]),
      .cleanOut (lineClean[li])
    );
  end

  i2cTgtCtrl #(.TGT_ADDR(TGT_ADDR)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclF   (lineClean[0]),
    .sdaF   (lineClean[1]),
    .rxByte (rxByte),
    .txBit  (txBit),
    .stb    (stb),
    .sdaOe  (sdaOe)
  );

  i2cTgtData u_data (
    .clk     (clk),
    .rstN    (rstN),
    .regClrN (regClrN),
    .stb     (stb),
    .sdaBit  (lineClean[1]),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .regOut  (regOut)
  );

  assign cfgReg0    = regOut[0];
  assign cfgReg1    = regOut[1];
  assign marginCode = regOut[0][MARGIN_W-1:0];
endmodule

// File: tb/sim_dual_cfg_i2c_target.sv
`timescale 1ns/1ps
module sim_dual_cfg_i2c_target;
  localparam logic [6:0] ADDR = 7'h4C;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regClrN = 1'b1;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaOe;
  logic [7:0] cfgReg0, cfgReg1;
  logic [5:0] marginCode;
  wire  sdaLine = sdaDrv & ~sdaOe;

  int nVec = 0;
  int nBad = 0;
  logic cmpEn = 1'b0;
  logic done = 1'b0;
  logic prevOe = 1'b0;
  logic [7:0] m [2];
  int mptr = 0;

  always #2.5 clk = ~clk;

  dual_cfg_i2c_target #(.TGT_ADDR(ADDR), .FILT_CYC(3)) u0 (
    .clk(clk), .rstN(rstN), .regClrN(regClrN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .cfgReg0(cfgReg0), .cfgReg1(cfgReg1), .marginCode(marginCode)
  );

  function automatic void check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endfunction

  // per-clock comparison against the reference registers (R2 R3 R9 R10)
  always @(negedge clk) begin
    if (cmpEn) begin
      check(cfgReg0 === m[0], "R2 reg0", cfgReg0, m[0]);
      check(cfgReg1 === m[1], "R3 reg1", cfgReg1, m[1]);
      check(marginCode === m[0][5:0], "R10 margin", {2'b0, marginCode}, {2'b0, m[0][5:0]});
    end
    if (rstN && (sdaOe !== prevOe)) check(!sclDrv, "R11 oe edge with scl high", {7'b0, sclDrv}, 8'h00);
    prevOe = sdaOe;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    sdaDrv = 1'b0; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sclDrv = 1'b0; sdaDrv = 1'b0; tick(Q);
    sclDrv = 1'b1; tick(Q);
    sdaDrv = 1'b1; tick(2 * Q);
  endtask

  task automatic clockBit(input logic b, input logic glitch, output logic seen);
    sdaDrv = b;
    if (glitch) begin
      tick(Q / 2);
      sclDrv = 1'b1; tick(2);
      sclDrv = 1'b0; tick(Q / 2 - 2);
    end else begin
      tick(Q);
    end
    sclDrv = 1'b1; tick(Q);
    seen = sdaLine; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input int glitchBit, input string req);
    logic s;
    cmpEn = 1'b0;
    for (int i = 7; i >= 0; i--) clockBit(b[i], i == glitchBit, s);
    clockBit(1'b1, 1'b0, s);
    check(s === !expAck, req, {7'b0, s}, {7'b0, !expAck});
  endtask

  task automatic recvByte(output logic [7:0] b, input logic giveAck);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, 1'b0, s);
      b[i] = s;
    end
    clockBit(!giveAck, 1'b0, s);
  endtask

  task automatic modelWrite(input logic [7:0] v);
    if (mptr < 2) m[mptr] = v;
    if (mptr == 0) mptr = 1;
  endtask

  task automatic writeTxn(input logic [7:0] ptr, input int n, input logic [7:0] d0, d1, d2, input string req);
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    busStart();
    sendByte({ADDR, 1'b0}, 1'b1, -1, "R1 addr ack");
    sendByte(ptr, 1'b1, -1, req);
    mptr = ptr;
    cmpEn = 1'b1;
    for (int k = 0; k < n; k++) begin
      sendByte(d[k], 1'b1, -1, req);
      modelWrite(d[k]);
      cmpEn = 1'b1;
    end
    busStop();
  endtask

  task automatic readTxn(input int n, input string req);
    logic [7:0] v, e;
    busStart();
    sendByte({ADDR, 1'b1}, 1'b1, -1, "R5 read addr ack");
    cmpEn = 1'b1;
    for (int k = 0; k < n; k++) begin
      recvByte(v, k < n - 1);
      e = (mptr < 2) ? m[mptr] : 8'h00;
      check(v === e, req, v, e);
      if (mptr == 0) mptr = 1;
    end
    busStop();
  endtask

  initial begin
    logic [7:0] v;
    logic s;
    m[0] = 8'h00; m[1] = 8'h00;
    tick(5);
    // R8: reset state
    check(cfgReg0 === 8'h00 && cfgReg1 === 8'h00, "R8 reset regs", cfgReg0 | cfgReg1, 8'h00);
    check(sdaOe === 1'b0, "R8 reset sdaOe", {7'b0, sdaOe}, 8'h00);
    rstN = 1'b1; tick(4);
    cmpEn = 1'b1;

    writeTxn(8'h01, 1, 8'hA7, 8'h00, 8'h00, "R2 single write");
    writeTxn(8'h01, 0, 8'h00, 8'h00, 8'h00, "R5 pointer only");
    readTxn(1, "R5 read after stop");
    writeTxn(8'h00, 2, 8'h3C, 8'h81, 8'h00, "R3 burst write");
    readTxn(1, "R7 ptr at reg1 after burst");
    writeTxn(8'h00, 0, 8'h00, 8'h00, 8'h00, "R6 pointer zero");
    readTxn(2, "R6 burst read");
    readTxn(1, "R7 saturated read");
    writeTxn(8'h00, 3, 8'h15, 8'h22, 8'h9E, "R3 three byte burst");
    writeTxn(8'h05, 1, 8'hFF, 8'h00, 8'h00, "R4 wild ptr write ack");
    readTxn(1, "R4 wild ptr read");

    // R1: wrong address, target stays silent
    busStart();
    sendByte({ADDR ^ 7'h01, 1'b0}, 1'b0, -1, "R1 mismatch nack");
    sendByte(8'h00, 1'b0, -1, "R1 ignored ptr");
    sendByte(8'h55, 1'b0, -1, "R1 ignored data");
    cmpEn = 1'b1;
    busStop();

    // R12: repeated START mid-byte
    busStart();
    sendByte({ADDR, 1'b0}, 1'b1, -1, "R12 addr");
    sendByte(8'h00, 1'b1, -1, "R12 ptr");
    mptr = 0; cmpEn = 1'b1;
    for (int i = 0; i < 4; i++) clockBit(1'b0, 1'b0, s);
    busStart();
    sendByte({ADDR, 1'b1}, 1'b1, -1, "R12 restart addr");
    cmpEn = 1'b1;
    recvByte(v, 1'b0);
    check(v === m[0], "R12 abort then read", v, m[0]);
    mptr = 1;
    busStop();

    // R12: STOP mid-byte
    busStart();
    sendByte({ADDR, 1'b0}, 1'b1, -1, "R12 addr");
    sendByte(8'h01, 1'b1, -1, "R12 ptr");
    mptr = 1; cmpEn = 1'b1;
    for (int i = 0; i < 3; i++) clockBit(1'b0, 1'b0, s);
    busStop();
    readTxn(1, "R12 stop keeps reg1");

    // R9: clear in the middle of a write keeps the pointer
    busStart();
    sendByte({ADDR, 1'b0}, 1'b1, -1, "R9 addr");
    sendByte(8'h01, 1'b1, -1, "R9 ptr");
    mptr = 1;
    cmpEn = 1'b1;
    m[0] = 8'h00; m[1] = 8'h00; regClrN = 1'b0;
    tick(3);
    regClrN = 1'b1;
    sendByte(8'h77, 1'b1, -1, "R9 data after clear");
    modelWrite(8'h77);
    cmpEn = 1'b1;
    busStop();
    check(cfgReg1 === 8'h77, "R9 write lands in reg1", cfgReg1, 8'h77);

    // R13: short SCL glitch inside a data byte
    busStart();
    sendByte({ADDR, 1'b0}, 1'b1, -1, "R13 addr");
    sendByte(8'h00, 1'b1, -1, "R13 ptr");
    mptr = 0;
    sendByte(8'hC5, 1'b1, 3, "R13 glitched byte ack");
    modelWrite(8'hC5);
    cmpEn = 1'b1;
    busStop();
    check(cfgReg0 === 8'hC5, "R13 glitch ignored", cfgReg0, 8'hC5);
    check({2'b0, marginCode} === 8'h05, "R10 margin field", {2'b0, marginCode}, 8'h05);

    // R8: reset in operation
    rstN = 1'b0; m[0] = 8'h00; m[1] = 8'h00; mptr = 0;
    tick(3);
    check(sdaOe === 1'b0, "R8 reset oe", {7'b0, sdaOe}, 8'h00);
    rstN = 1'b1; tick(4);
    writeTxn(8'h01, 1, 8'h4E, 8'h00, 8'h00, "R8 write after reset");
    writeTxn(8'h00, 0, 8'h00, 8'h00, 8'h00, "R8 pointer");
    readTxn(2, "R8 read after reset");

    tick(10);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog R12: got hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule